// File: doc/BRIEF.md
# General-Purpose I/O Controller with Change Interrupts

This block is a memory-mapped controller for up to 32 general-purpose lines. Software sets a per-line direction, drives output levels through one data register, and reads back line states through that same register. Every line feeds a change detector that latches any transition, rising or falling, into a status register. Software clears a latched bit by writing a one to it. A single interrupt output is raised while any latched change is also enabled.

Pin inputs are resynchronised through two flops before they are used. The edge detector compares the synchronised value with its value one cycle earlier. The register port is a plain single-cycle access with no back-pressure. A write takes effect at the clock edge where `reg_wr` is high. Read data is a combinational function of `reg_addr` and the register state. Address bits [1:0] are ignored. Word index 6 and above read as zero and ignore writes.

Top module: `gpio_chg_ctrl`

## Requirements
- R1: All registers reset to 0, except the write mask, which resets to ones in every implemented bit. The direction (byte offset 0x00), enable (0x08) and write-mask (0x10) registers read back the last value written.
- R2: `pin_oe` equals the direction register, where 1 means output. `pin_out` equals the driven value held by the data register.
- R3: A read of the data register (offset 0x04) returns the driven value for output lines. For input lines it returns the pin value delayed by the two-stage synchroniser, so a pin change is visible two clock edges later.
- R4: A write to the data register updates only the bits whose write-mask bit is 1. All other driven bits keep their previous value.
- R5: A rising or a falling transition on a line sets its bit in the change register (offset 0x0C). The bit becomes visible three clock edges after the pin changes.
- R6: Writing 1 to a change-register bit clears it. Writing 0 leaves the bit unchanged. No change bit is set without a detected edge.
- R7: When an edge is detected in the same cycle as a clearing write to that bit, the bit ends up set.
- R8: `irq` is high exactly while any bit of (change AND enable) is 1. It can fall only after a register write.
- R9: The interrupt-type register (offset 0x14) is read/write storage. Its value has no effect on edge detection.
- R10: Register bits at or above NUM_LINES read as 0. Word index 6 and above reads as 0 and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, taken at the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pin_in | input | NUM_LINES | Asynchronous line inputs |
| pin_out | output | NUM_LINES | Driven output levels |
| pin_oe | output | NUM_LINES | Per-line output enable |
| irq | output | 1 | Combined change interrupt |

## Verification
The bench aims a clearing write at the exact cycle in which a new edge is detected on the same bit. A design where the clear wins would silently drop that event and leave the change bit at 0. It changes the write mask before writing data. Ignoring the mask would overwrite driven bits the mask should protect. It also reads the data register on a mix of input and output lines. Selecting the wrong source per line would return stale pin values for outputs or driven values for inputs. Falling edges, writes of 0 to the change register, and accesses to bits and words beyond the implemented range are also covered. Each of these would expose a single-edge detector, an over-eager clear or missing masking of the unused bits.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  localparam int REG_W = 32;
  typedef enum logic [2:0] {
    RI_DIR  = 3'd0,
    RI_DATA = 3'd1,
    RI_IEN  = 3'd2,
    RI_CHG  = 3'd3,
    RI_MASK = 3'd4,
    RI_TYPE = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] sync_o,
  output logic [NUM_LINES-1:0] edge_o
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic meta_q, stab_q, last_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
        last_q <= 1'b0;
      end else begin
        meta_q <= pin_in[g];
        stab_q <= meta_q;
        last_q <= stab_q;
      end
    end
    assign sync_o[g] = stab_q;
    assign edge_o[g] = stab_q ^ last_q;
  end
endmodule

// File: rtl/gpio_chg_latch.sv
module gpio_chg_latch #(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] edge_i,
  input  logic                 clr_en,
  input  logic [NUM_LINES-1:0] clr_bits,
  input  logic [NUM_LINES-1:0] ien_i,
  output logic [NUM_LINES-1:0] chg_o,
  output logic                 irq_o
);
  logic [NUM_LINES-1:0] chg_q;
  logic [NUM_LINES-1:0] clr_eff;

  assign clr_eff = clr_en ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chg_q <= '0;
    else        chg_q <= (chg_q & ~clr_eff) | edge_i;
  end

  assign chg_o = chg_q;
  assign irq_o = |(chg_q & ien_i);

  // R5
  edge_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_i) |=> ((chg_q & $past(edge_i)) == $past(edge_i)));
  // R6
  clear_without_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((chg_q & $past(clr_bits & ~edge_i)) == '0));
  // R6
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((chg_q & ~$past(chg_q)) & ~$past(edge_i)) == '0);
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_chg_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  reg_idx_e             wr_idx,
  input  logic [NUM_LINES-1:0] wdata,
  output logic [NUM_LINES-1:0] dir_o,
  output logic [NUM_LINES-1:0] dout_o,
  output logic [NUM_LINES-1:0] ien_o,
  output logic [NUM_LINES-1:0] mask_o,
  output logic [NUM_LINES-1:0] type_o
);
  logic [NUM_LINES-1:0] dir_q, dout_q, ien_q, mask_q, type_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
      ien_q  <= '0;
      mask_q <= '1;
      type_q <= '0;
    end else if (wr_en) begin
      case (wr_idx)
        RI_DIR:  dir_q  <= wdata;
        RI_DATA: dout_q <= (dout_q & ~mask_q) | (wdata & mask_q);
        RI_IEN:  ien_q  <= wdata;
        RI_MASK: mask_q <= wdata;
        RI_TYPE: type_q <= wdata;
        default: ;
      endcase
    end
  end

  assign dir_o  = dir_q;
  assign dout_o = dout_q;
  assign ien_o  = ien_q;
  assign mask_o = mask_q;
  assign type_o = type_q;

  // R4
  masked_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == RI_DATA) |=> (((dout_q ^ $past(dout_q)) & ~$past(mask_q)) == '0));
endmodule

// File: rtl/gpio_chg_ctrl.sv
module gpio_chg_ctrl
  import gpio_chg_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] pin_oe,
  output logic                 irq
);
  localparam int WORD_W   = ADDR_W - 2;
  localparam int LAST_IDX = 5;

  logic [WORD_W-1:0]    word;
  logic                 hit;
  reg_idx_e             idx;
  logic [NUM_LINES-1:0] wd_n, sync_v, edge_v, chg_v;
  logic [NUM_LINES-1:0] dir_v, dout_v, ien_v, mask_v, type_v, data_rd;
  logic                 unused_lo;

  assign word      = reg_addr[ADDR_W-1:2];
  assign hit       = word <= WORD_W'(LAST_IDX);
  assign idx       = reg_idx_e'(word[2:0]);
  assign wd_n      = reg_wdata[NUM_LINES-1:0];
  assign unused_lo = ^{reg_addr[1:0], reg_wdata};

  gpio_in_sync #(.NUM_LINES(NUM_LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sync_o(sync_v), .edge_o(edge_v)
  );

  gpio_cfg_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr && hit), .wr_idx(idx), .wdata(wd_n),
    .dir_o(dir_v), .dout_o(dout_v), .ien_o(ien_v), .mask_o(mask_v), .type_o(type_v)
  );

  gpio_chg_latch #(.NUM_LINES(NUM_LINES)) u_chg (
    .clk(clk), .rst_n(rst_n), .edge_i(edge_v),
    .clr_en(reg_wr && hit && idx == RI_CHG), .clr_bits(wd_n),
    .ien_i(ien_v), .chg_o(chg_v), .irq_o(irq)
  );

  assign data_rd = (dout_v & dir_v) | (sync_v & ~dir_v);
  assign pin_out = dout_v;
  assign pin_oe  = dir_v;

  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      case (idx)
        RI_DIR:  reg_rdata = REG_W'(dir_v);
        RI_DATA: reg_rdata = REG_W'(data_rd);
        RI_IEN:  reg_rdata = REG_W'(ien_v);
        RI_CHG:  reg_rdata = REG_W'(chg_v);
        RI_MASK: reg_rdata = REG_W'(mask_v);
        RI_TYPE: reg_rdata = REG_W'(type_v);
        default: reg_rdata = '0;
      endcase
    end
  end

  // R8
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(reg_wr));
endmodule

// File: tb/gpio_chg_ctrl_test.sv
module gpio_chg_ctrl_test;
  localparam int N  = 12;
  localparam int AW = 5;
  localparam logic [31:0] LM = (32'd1 << N) - 1;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] reg_addr = '0;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [N-1:0] pin_in = '0, pin_out, pin_oe;
  logic irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_chg_ctrl #(.NUM_LINES(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // behavioural reference
  logic [31:0] m_dir, m_dout, m_ien, m_chg, m_mask, m_type, m_s1, m_s2, m_prev;
  always @(posedge clk) begin
    logic [31:0] ed, clr, wd;
    int w;
    if (!rst_n) begin
      m_dir = 0; m_dout = 0; m_ien = 0; m_chg = 0; m_mask = LM; m_type = 0;
      m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      w   = int'(reg_addr) / 4;
      wd  = reg_wdata & LM;
      ed  = m_s2 ^ m_prev;
      clr = (reg_wr && w == 3) ? wd : 0;
      m_chg  = (m_chg & ~clr) | ed;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = 32'(pin_in);
      if (reg_wr) begin
        if (w == 0) m_dir = wd;
        if (w == 1) m_dout = (m_dout & ~m_mask) | (wd & m_mask);
        if (w == 2) m_ien = wd;
        if (w == 4) m_mask = wd;
        if (w == 5) m_type = wd;
      end
    end
  end

  function automatic logic [31:0] exp_rd(int w);
    case (w)
      0: return m_dir;
      1: return (m_dout & m_dir) | (m_s2 & ~m_dir);
      2: return m_ien;
      3: return m_chg;
      4: return m_mask;
      5: return m_type;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int w);
    case (w)
      1: return "R3";
      3: return "R5";
      4: return "R4";
      5: return "R9";
      0, 2: return "R1";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    #1.5;
    if (rst_n && !done) begin
      chk(tag_of(int'(reg_addr) / 4), reg_rdata, exp_rd(int'(reg_addr) / 4));
      chk("R8 irq", 32'(irq), 32'(|(m_chg & m_ien)));
      chk("R2 pin_out", 32'(pin_out), m_dout);
      chk("R2 pin_oe", 32'(pin_oe), m_dir);
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); reg_addr = AW'(a); reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_chk(int a, logic [31:0] msk, logic [31:0] exp, string tag);
    @(negedge clk); reg_addr = AW'(a); #1;
    chk(tag, reg_rdata & msk, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_chk(16, 32'hFFFF_FFFF, LM, "R1 mask reset");
    rd_chk(0, 32'hFFFF_FFFF, 0, "R1 dir reset");
    rd_chk(12, 32'hFFFF_FFFF, 0, "R1 chg reset");
    wr(0, 32'hFFFF_F0F0);
    rd_chk(0, 32'hFFFF_FFFF, 32'h0F0, "R10 upper bits");
    wr(4, 32'hAAA);
    rd_chk(4, 32'h0F0, 32'h0A0, "R3 output readback");
    wr(16, 32'h00F);
    wr(4, 32'h555);
    @(negedge clk); #1; chk("R4 masked write", 32'(pin_out), 32'hAA5);
    wr(16, LM);
    // inputs: rising edges then visible after sync
    @(negedge clk); pin_in = 12'h003;
    rd_chk(12, 32'hFFFF_FFFF, 0, "R5 not yet");
    repeat (2) @(negedge clk);
    rd_chk(4, 32'h003, 32'h003, "R3 synced input");
    rd_chk(12, 32'h003, 32'h003, "R5 rising");
    wr(8, 32'h001);
    @(negedge clk); #1; chk("R8 irq on", 32'(irq), 1);
    wr(12, 32'h000);
    rd_chk(12, 32'h003, 32'h003, "R6 zero write");
    wr(12, 32'h001);
    rd_chk(12, 32'h003, 32'h002, "R6 one clears");
    @(negedge clk); #1; chk("R8 irq off", 32'(irq), 0);
    // falling edge
    @(negedge clk); pin_in = 12'h002;
    repeat (4) @(negedge clk);
    rd_chk(12, 32'h001, 32'h001, "R5 falling");
    // set beats clear
    wr(12, LM);
    @(negedge clk); pin_in = 12'h006;
    repeat (4) @(negedge clk);
    @(negedge clk); pin_in = 12'h002;
    @(negedge clk);
    wr(12, 32'h004);
    rd_chk(12, 32'h004, 32'h004, "R7 set wins");
    // type register has no effect
    wr(20, LM);
    rd_chk(20, 32'hFFFF_FFFF, LM, "R9 readback");
    wr(12, LM);
    @(negedge clk); pin_in = 12'h802;
    repeat (4) @(negedge clk);
    rd_chk(12, 32'hFFFF_FFFF, 32'h800, "R9 detection unchanged");
    // unused words
    wr(24, 32'h123);
    rd_chk(24, 32'hFFFF_FFFF, 0, "R10 unused word");
    // random traffic
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      reg_addr  = AW'($urandom_range(0, 31));
      reg_wr    = ($urandom_range(0, 3) == 0);
      reg_wdata = $urandom;
      if ($urandom_range(0, 2) == 0) pin_in = N'($urandom);
    end
    @(negedge clk); reg_wr = 0;
    repeat (4) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule